// File: doc/BRIEF.md
# Flash Command Engine

This block sits behind a parallel flash bus port and turns a stream of single-clock write cycles into the classic two-step command protocol of NOR-style flash. A write cycle with the engine idle is taken as a command byte; some commands need one or more follow-up cycles: a data word, a confirm code or a word count. A write-cycle counter and a latched command decide how the following cycles are read. Reads are combinational from the read address and return one of four views: the storage array itself, the status byte, the identifier codes, or a small self-description (query) table.

Storage is a parameterised register array split into equal sectors. A sector erase does not finish at once: a sweeper writes all-ones into the sector one word per clock. While it runs, `busy` is high, the ready bit of the status view reads 0 and bus writes are dropped. A write-protect input turns every program or erase into a failure that is reported in the status byte. There is no real program timing, no suspend, no lock enforcement and no separate staging buffer: buffered writes go straight to the array.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the read view is the array, every array word reads all-ones, the cycle counter is idle, `busy` is low and the status byte is 0x80.
- R2: An idle write of 0x10 or 0x40 arms a program. The next accepted write stores its data at its address and returns to idle with status bit 7 set. Reads then return status until another command is given.
- R3: An idle write of 0x20 starts an erase of the sector holding the address. Over the next SECTOR_WORDS clocks the words of that sector become all-ones, one per clock, in rising address order. `busy` is high over those clocks, status bit 7 reads 0, and any bus write presented meanwhile has no effect.
- R4: The cycle after an erase command accepts 0xD0 as confirm (idle, status view, bit 7 set). 0xFF, or any other value, returns to the array view.
- R5: With `wr_protect` high, storage is never changed. A program or buffered word sets status bit 4, an erase sets status bit 5 and starts no sweep, and both set bit 7.
- R6: An idle 0x50 clears the status byte to 0x00 and selects the array view. An idle 0x70 selects the status view. An idle 0xFF, 0xF0 or 0x00 selects the array view.
- R7: After an idle 0x90, a read at word address 0 returns the manufacturer code (MFR_ID), address 1 returns the device code (DEV_ID) and any other address returns 0, in every lane.
- R8: After an idle 0x98, reads return query bytes indexed by word address: 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59; 0x13 gives 0x01; 0x27 gives log2 of the array size in bytes; 0x2C gives 0x01; every other index gives 0. Further writes other than 0xFF leave the query view in place, and 0xFF returns to the array view.
- R9: An idle 0xE8 starts a buffered write and sets status bit 7. The next cycle latches a count N from the low DEV_W data bits. The following N+1 writes each store one word at their address. One more cycle then accepts 0xD0 to finish in the status view; any other value aborts to the array view, and the stored words stay.
- R10: An idle 0x60 arms a lock operation. A next write of 0xD0 or 0x01 completes it (idle, status view, bit 7 set); any other value returns to the array view.
- R11: Any idle command byte outside the listed set returns the engine to the array view with the cycle counter idle.
- R12: In every view other than array, identifier and query, reads return the status byte copied into each DEV_W-wide lane of the read word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_protect | input | 1 | Make programs and erases fail without changing storage |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | ADDR_W | Word address of the write cycle |
| wr_data | input | DATA_W | Write data; the low byte carries command codes |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data in the current view |
| busy | output | 1 | Erase sweep in progress |

## Verification
A wrong cycle counter or latched command shows up on the next read as the wrong view: array data where the status lanes belong, or the reverse. The ready bit exposes a sweep that ends one clock early or late on the very clock it happens, and a sweep that misses a word or writes the wrong sector shows up the first time that sector is read back after the engine returns to the array view. Status flags that should stick, such as the error bits, are caught on the first status read after the failing cycle.

// File: rtl/fce_pkg.sv
package fce_pkg;

  typedef enum logic [2:0] {
    M_ARRAY, M_PROG, M_ERASE, M_LOCK, M_STAT, M_BUF, M_IDENT, M_QUERY
  } rmode_e;

  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUF      = 8'hE8;
  localparam logic [7:0] OP_RD       = 8'hFF;
  localparam logic [7:0] OP_RD_ALT   = 8'hF0;
  localparam logic [7:0] OP_NULL     = 8'h00;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  // Views that return the status byte in every lane.
  function automatic logic shows_status(rmode_e m);
    return (m != M_ARRAY) && (m != M_IDENT) && (m != M_QUERY);
  endfunction

  function automatic logic [7:0] ident_byte(logic [7:0] idx, logic [7:0] mfr,
                                            logic [7:0] dev);
    case (idx)
      8'h00:   return mfr;
      8'h01:   return dev;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] query_byte(logic [7:0] idx, logic [7:0] size_log2);
    case (idx)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return size_log2;
      8'h2C:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fce_array.sv
module fce_array #(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 64,
  parameter int SECTOR_WORDS = 16,
  parameter int ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_go,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'(SECTOR_WORDS - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic              sweep_last;

  assign sweep_last = (ptr & SEC_MASK) == SEC_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (erase_go) begin
      busy <= 1'b1;
      ptr  <= erase_addr & ~SEC_MASK;
    end else if (busy) begin
      ptr <= ptr + ADDR_W'(1);
      if (sweep_last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (busy) begin
      mem[ptr] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ro,
  input  logic             wr_en,
  input  logic             busy,
  input  logic [7:0]       op,
  input  logic [DEV_W-1:0] cnt_in,
  output logic             prog_we,
  output logic             erase_go,
  output rmode_e           mode_q,
  output logic [1:0]       cyc_q,
  output logic [7:0]       status_q,
  output logic [DEV_W-1:0] cnt_q
);
  rmode_e           n_mode;
  logic [1:0]       n_cyc;
  logic [7:0]       n_st;
  logic [DEV_W-1:0] n_cnt;
  logic             acc;
  logic             to_array;
  logic [7:0]       prog_flags;

  assign acc        = wr_en & ~busy;
  assign prog_flags = ST_READY | (ro ? ST_PROG_ERR : 8'h00);

  always_comb begin
    n_mode   = mode_q;
    n_cyc    = cyc_q;
    n_st     = status_q;
    n_cnt    = cnt_q;
    prog_we  = 1'b0;
    erase_go = 1'b0;
    to_array = 1'b0;
    if (acc) begin
      case (cyc_q)
        2'd0: begin
          case (op)
            OP_PROG_A, OP_PROG_B: begin n_mode = M_PROG;  n_cyc = 2'd1; end
            OP_ERASE: begin
              n_mode   = M_ERASE;
              n_cyc    = 2'd1;
              n_st     = status_q | ST_READY | (ro ? ST_ERASE_ERR : 8'h00);
              erase_go = ~ro;
            end
            OP_CLEAR: begin n_st = 8'h00; to_array = 1'b1; end
            OP_LOCK:  begin n_mode = M_LOCK;  n_cyc = 2'd1; end
            OP_STAT:  n_mode = M_STAT;
            OP_IDENT: n_mode = M_IDENT;
            OP_QUERY: begin n_mode = M_QUERY; n_cyc = 2'd1; end
            OP_BUF:   begin n_mode = M_BUF; n_cyc = 2'd1; n_st = status_q | ST_READY; end
            OP_RD, OP_RD_ALT, OP_NULL: to_array = 1'b1;
            default:  to_array = 1'b1;
          endcase
        end
        2'd1: begin
          case (mode_q)
            M_PROG: begin
              prog_we = ~ro;
              n_st    = status_q | prog_flags;
              n_cyc   = 2'd0;
            end
            M_ERASE: begin
              if (op == OP_CONFIRM) begin n_cyc = 2'd0; n_st = status_q | ST_READY; end
              else to_array = 1'b1;
            end
            M_LOCK: begin
              if (op == OP_CONFIRM || op == OP_LOCK_ALT) begin
                n_cyc = 2'd0;
                n_st  = status_q | ST_READY;
              end else to_array = 1'b1;
            end
            M_BUF: begin n_cnt = cnt_in; n_cyc = 2'd2; end
            M_QUERY: if (op == OP_RD) to_array = 1'b1;
            default: to_array = 1'b1;
          endcase
        end
        2'd2: begin
          if (mode_q == M_BUF) begin
            prog_we = ~ro;
            n_st    = status_q | prog_flags;
            if (cnt_q == '0) n_cyc = 2'd3;
            n_cnt = cnt_q - DEV_W'(1);
          end else to_array = 1'b1;
        end
        default: begin
          if (mode_q == M_BUF && op == OP_CONFIRM) begin
            n_cyc = 2'd0;
            n_st  = status_q | ST_READY;
          end else to_array = 1'b1;
        end
      endcase
    end
    if (to_array) begin
      n_mode = M_ARRAY;
      n_cyc  = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_ARRAY;
      cyc_q    <= 2'd0;
      status_q <= ST_READY;
      cnt_q    <= '0;
    end else begin
      mode_q   <= n_mode;
      cyc_q    <= n_cyc;
      status_q <= n_st;
      cnt_q    <= n_cnt;
    end
  end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int         DATA_W       = 16,
  parameter int         DEV_W        = 8,
  parameter int         DEPTH        = 64,
  parameter int         SECTOR_WORDS = 16,
  parameter logic [7:0] MFR_ID       = 8'h89,
  parameter logic [7:0] DEV_ID       = 8'h18,
  parameter int         ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_protect,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int         LANES     = DATA_W / DEV_W;
  localparam logic [7:0] SIZE_LOG2 = 8'($clog2(DEPTH * DATA_W / 8));

  rmode_e            mode_q;
  logic [1:0]        cyc_q;
  logic [7:0]        status_q;
  logic [DEV_W-1:0]  cnt_q;
  logic              prog_we;
  logic              erase_go;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] rep_word;
  logic [7:0]        st_view;
  logic [7:0]        lane_byte;
  logic [7:0]        rd_idx;

  fce_seq #(.DEV_W(DEV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ro(wr_protect), .wr_en(wr_en), .busy(busy),
    .op(wr_data[7:0]), .cnt_in(wr_data[DEV_W-1:0]),
    .prog_we(prog_we), .erase_go(erase_go), .mode_q(mode_q),
    .cyc_q(cyc_q), .status_q(status_q), .cnt_q(cnt_q)
  );

  fce_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SECTOR_WORDS(SECTOR_WORDS),
              .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(prog_we), .waddr(wr_addr), .wdata(wr_data),
    .erase_go(erase_go), .erase_addr(wr_addr), .raddr(rd_addr),
    .rdata(arr_word), .busy(busy)
  );

  // Ready bit is hidden while the sweeper runs.
  assign st_view = {status_q[7] & ~busy, status_q[6:0]};
  assign rd_idx  = 8'(rd_addr);

  always_comb begin
    case (mode_q)
      M_IDENT: lane_byte = ident_byte(rd_idx, MFR_ID, DEV_ID);
      M_QUERY: lane_byte = query_byte(rd_idx, SIZE_LOG2);
      default: lane_byte = st_view;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rep_word[l*DEV_W +: DEV_W] = DEV_W'(lane_byte);
  end

  assign rd_data = (mode_q == M_ARRAY) ? arr_word : rep_word;

endmodule

// File: rtl/fce_checker.sv
module fce_checker
  import fce_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ro,
  input logic              wr_en,
  input logic [7:0]        wr_op,
  input logic              busy,
  input logic [DATA_W-1:0] rd_data,
  input rmode_e            mode,
  input logic [1:0]        cyc,
  input logic [7:0]        status,
  input logic [DEV_W-1:0]  cnt,
  input logic              prog_we,
  input logic              erase_go
);
  // R3
  busy_hides_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && shows_status(mode)) |-> (rd_data[7] == 1'b0));

  // R3
  sweep_blocks_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_we);

  // R3
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && cyc == 2'd0 && wr_op == 8'h20 && !ro) |=> busy);

  // R2
  prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && cyc == 2'd1 && mode == M_PROG) |=> (cyc == 2'd0 && status[7]));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && cyc == 2'd0 && wr_op == 8'h50)
      |=> (status == 8'h00 && mode == M_ARRAY && cyc == 2'd0));

  // R9
  buf_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && cyc == 2'd2 && mode == M_BUF && cnt == '0) |=> (cyc == 2'd3));

  // R5
  ro_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro |-> (!prog_we && !erase_go));

  // R12
  lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shows_status(mode) |-> (rd_data[DEV_W-1:0] == rd_data[DATA_W-1 -: DEV_W]));

endmodule

bind flash_cmd_engine fce_checker #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ro(wr_protect), .wr_en(wr_en), .wr_op(wr_data[7:0]),
  .busy(busy), .rd_data(rd_data), .mode(mode_q), .cyc(cyc_q), .status(status_q),
  .cnt(cnt_q), .prog_we(prog_we), .erase_go(erase_go)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEC = 16;
  localparam int MFR = 'h89;
  localparam int DEV = 'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_protect = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference: rmode 0 array, 1 status, 2 ident, 3 query.
  int m_mem [64];
  int m_rmode = 0, m_phase = 0, m_pend = 0, m_st = 'h80, m_left = 0;
  int m_busy = 0, m_sweep = 0;

  flash_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int qry(int ra);
    case (ra)
      'h10: return 'h51;
      'h11: return 'h52;
      'h12: return 'h59;
      'h13: return 1;
      'h27: return 7;
      'h2C: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_rd(int ra);
    int b;
    if (m_rmode == 0) return m_mem[ra];
    if (m_rmode == 2) b = (ra == 0) ? MFR : (ra == 1) ? DEV : 0;
    else if (m_rmode == 3) b = qry(ra);
    else b = (m_busy > 0) ? (m_st & 'h7F) : m_st;
    return b * 257;
  endfunction

  task automatic to_array();
    m_rmode = 0; m_phase = 0;
  endtask

  task automatic mdl_edge(bit we, int a, int d);
    bit acc;
    int op;
    acc = we && (m_busy == 0);
    if (m_busy > 0) begin m_mem[m_sweep] = 'hFFFF; m_sweep++; m_busy--; end
    if (!acc) return;
    op = d & 255;
    if (m_phase == 0) begin
      if (op == 'h10 || op == 'h40) begin m_pend = 'h10; m_phase = 1; m_rmode = 1; end
      else if (op == 'h20) begin
        m_pend = 'h20; m_phase = 1; m_rmode = 1;
        m_st |= wr_protect ? 'hA0 : 'h80;
        if (!wr_protect) begin m_busy = SEC; m_sweep = a - (a % SEC); end
      end
      else if (op == 'h50) begin m_st = 0; to_array(); end
      else if (op == 'h60) begin m_pend = 'h60; m_phase = 1; m_rmode = 1; end
      else if (op == 'h70) m_rmode = 1;
      else if (op == 'h90) m_rmode = 2;
      else if (op == 'h98) begin m_pend = 'h98; m_phase = 1; m_rmode = 3; end
      else if (op == 'hE8) begin m_pend = 'hE8; m_phase = 1; m_rmode = 1; m_st |= 'h80; end
      else to_array();
    end else if (m_phase == 1) begin
      if (m_pend == 'h10) begin
        if (wr_protect) m_st |= 'h10; else m_mem[a] = d;
        m_st |= 'h80; m_phase = 0;
      end else if (m_pend == 'h20 || m_pend == 'h60) begin
        if (op == 'hD0 || (m_pend == 'h60 && op == 1)) begin m_phase = 0; m_st |= 'h80; end
        else to_array();
      end else if (m_pend == 'hE8) begin
        m_left = d & 255; m_phase = 2;
      end else if (op == 'hFF) to_array();
    end else if (m_phase == 2) begin
      if (wr_protect) m_st |= 'h10; else m_mem[a] = d;
      m_st |= 'h80;
      if (m_left == 0) m_phase = 3;
      m_left--;
    end else begin
      if (op == 'hD0) begin m_phase = 0; m_st |= 'h80; end
      else to_array();
    end
  endtask

  task automatic check_now(string tag);
    int e;
    e = exp_rd(int'(rd_addr));
    n_cmp++;
    if (rd_data !== 16'(e)) begin
      n_bad++;
      $display("FAIL %s rd_data @addr %0d actual=%h expected=%h", tag, rd_addr, rd_data, 16'(e));
    end
    n_cmp++;
    if (busy !== (m_busy > 0)) begin
      n_bad++;
      $display("FAIL %s busy actual=%b expected=%b", tag, busy, (m_busy > 0));
    end
  endtask

  task automatic step(string tag, bit we, int a, int d, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = 6'(a); wr_data = 16'(d); rd_addr = 6'(ra);
    #1;
    check_now(tag);
    @(posedge clk);
    mdl_edge(we, a, d);
  endtask

  task automatic wr(string tag, int a, int d);
    step(tag, 1'b1, a, d, 0);
  endtask

  task automatic rd(string tag, int ra);
    step(tag, 1'b0, 0, 0, ra);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: array of ones, then status 0x80
    rd("R1", 0); rd("R1", 37);
    wr("R1", 0, 'h70); rd("R1", 0);
    // R2 program, both opcodes; R12 status lanes afterwards
    wr("R2", 0, 'h40); wr("R2", 3, 'h1234); rd("R12", 3);
    wr("R2", 0, 'hFF); rd("R2", 3);
    wr("R2", 0, 'h10); wr("R2", 40, 'hABCD); wr("R2", 0, 'hF0); rd("R2", 40);
    // R6 clear, status select, read-array codes
    wr("R6", 0, 'h70); wr("R6", 0, 'h50); rd("R6", 3);
    wr("R6", 0, 'h70); rd("R6", 0); wr("R6", 0, 'h00); rd("R6", 40);
    // R7 identifier view
    wr("R7", 0, 'h90); rd("R7", 0); rd("R7", 1); rd("R7", 2); rd("R7", 63);
    wr("R7", 0, 'hFF); rd("R7", 3);
    // R8 query view, sticky until 0xFF
    wr("R8", 0, 'h98);
    rd("R8", 'h10); rd("R8", 'h11); rd("R8", 'h12); rd("R8", 'h13);
    rd("R8", 'h27); rd("R8", 'h2C); rd("R8", 5);
    wr("R8", 0, 'h90); rd("R8", 'h11);
    wr("R8", 0, 'hFF); rd("R8", 40);
    // R3 erase sweep of sector 1, with a dropped write while busy
    wr("R3", 0, 'h40); wr("R3", 20, 'h5555);
    wr("R3", 21, 'h20);
    for (int i = 0; i < 18; i++) step("R3", i == 4, 0, 'h50, 20 + i % 4);
    wr("R4", 0, 'hD0); rd("R4", 0);
    wr("R3", 0, 'hFF);
    for (int i = 16; i < 32; i++) rd("R3", i);
    rd("R3", 3); rd("R3", 40);
    // R4 second-cycle variants
    wr("R4", 50, 'h20);
    for (int i = 0; i < 17; i++) rd("R4", 0);
    wr("R4", 0, 'hFF); rd("R4", 50);
    wr("R4", 0, 'h40); wr("R4", 50, 'h0F0F); wr("R4", 50, 'h20);
    for (int i = 0; i < 17; i++) rd("R4", 50);
    wr("R4", 0, 'h12); rd("R4", 50);
    // R10 lock pairs
    wr("R10", 0, 'h60); wr("R10", 0, 'hD0); rd("R10", 0);
    wr("R10", 0, 'h60); wr("R10", 0, 'h01); rd("R10", 0);
    wr("R10", 0, 'h60); wr("R10", 0, 'h33); rd("R10", 3);
    // R9 buffered write, confirmed and aborted
    wr("R9", 8, 'hE8); wr("R9", 8, 'h0302); rd("R9", 8);
    wr("R9", 8, 'h1111); wr("R9", 9, 'h2222); wr("R9", 10, 'h3333);
    rd("R9", 8); wr("R9", 0, 'hD0); rd("R9", 0);
    wr("R9", 0, 'hFF); rd("R9", 8); rd("R9", 9); rd("R9", 10); rd("R9", 11);
    wr("R9", 12, 'hE8); wr("R9", 12, 0); wr("R9", 12, 'h4444); wr("R9", 0, 'h77);
    rd("R9", 12);
    // R11 unknown commands
    wr("R11", 0, 'h70); wr("R11", 0, 'h33); rd("R11", 12);
    wr("R11", 0, 'h42); rd("R11", 3);
    // R5 write protect
    wr_protect = 1'b1;
    wr("R5", 0, 'h50); wr("R5", 0, 'h40); wr("R5", 4, 'h9999); rd("R5", 0);
    wr("R5", 0, 'hFF); rd("R5", 4);
    wr("R5", 0, 'h50); wr("R5", 0, 'h20); rd("R5", 0); wr("R5", 0, 'hD0); rd("R5", 0);
    wr("R5", 0, 'hFF); rd("R5", 3);
    wr("R5", 0, 'h50); wr("R5", 6, 'hE8); wr("R5", 6, 0); wr("R5", 6, 'h7777);
    wr("R5", 0, 'hD0); rd("R5", 0); wr("R5", 0, 'hFF); rd("R5", 6);
    wr_protect = 1'b0;
    rd("R1", 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule